// File: doc/BRIEF.md
# Sizing-Aware Base Address Register

This block holds one base address register of a device configuration header. It can be built as a memory window or as an I/O window. The window size is a power of two, chosen at build time. Software writes the register as four byte lanes. The block clears the address bits that fall inside the window and keeps the type flag bits fixed. A read returns the register as it was stored.

The block also keeps a second value, the active base. This is the window the decoder should use right now. Writing all ones is the usual way to find a window's size, and such a write leaves the active base unchanged. Writing back the base that is already active also leaves it unchanged. Any other change raises a relocation event for one cycle. The event carries the old base and the new base, plus two hints: one says to release the old range, the other says to claim the new one. A zero base means the window is disabled.

Top module: `bar_reg`

## Requirements
- R1: After reset, `rdata_o` holds only the fixed flag bits. `base_o` is zero, `win_en_o` is low, and `reloc_o`, `release_o` and `claim_o` are low.
- R2: A write changes only the bytes whose `be_i` bit is set. `be_i[n]` selects `wdata_i[8n+7:8n]`. The stored value is readable on `rdata_o` from the cycle after the write edge.
- R3: Address bits below 2^SIZE_LOG2 always read back as zero, whatever was written.
- R4: In a memory window (`IS_IO`=0), bits 3:0 always read as `MEM_FLAGS` and ignore writes.
- R5: In an I/O window (`IS_IO`=1), bits 1:0 always read as `IO_FLAGS`. Bits 31:16 always read as zero, so only a 16-bit address is decoded.
- R6: The candidate base is the stored value with its flag bits cleared. A write whose candidate base equals the address mask is a sizing probe. It reads back as mask OR flags, raises no event, and leaves `base_o` unchanged.
- R7: A write whose candidate base equals the current `base_o` raises no event.
- R8: Any other write sets `reloc_o` for exactly the one cycle after the write edge. In that cycle `old_base_o` holds the previous `base_o` and `new_base_o` holds the new one. From that cycle on, `base_o` equals the new base.
- R9: During an event, `release_o` is set when the old base is non-zero, and `claim_o` is set when the new base is non-zero. Both are low outside an event.
- R10: `win_en_o` is high exactly when `base_o` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| be_i | input | 4 | Byte lane enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Stored register value |
| base_o | output | 32 | Active decoded base, flag bits clear |
| win_en_o | output | 1 | Window enabled (base non-zero) |
| reloc_o | output | 1 | One-cycle relocation event |
| old_base_o | output | 32 | Base before the relocation |
| new_base_o | output | 32 | Base after the relocation |
| release_o | output | 1 | Old range must be released |
| claim_o | output | 1 | New range must be claimed |

## Verification
The stored register and the active base can drift apart, and a fault in either one shows up at a specific time.

- A bad mask or a lost flag bit shows on `rdata_o` in the very next cycle.
- If the active base is wrongly updated by a sizing probe, nothing is visible at first. The fault only appears when the original base is restored: an event fires that should not.
- If the active base is stale, the next real relocation reports the wrong `old_base_o`. It may also drop `release_o`.

For this reason the tests run probe-then-restore sequences and chained relocations, not single writes.

// File: rtl/bar_pkg.sv
package bar_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned LANES = DW / 8;

  // Address mask with the flag field and in-window bits cleared
  function automatic logic [DW-1:0] addr_mask(input bit is_io, input int size_log2);
    logic [DW-1:0] m;
    m = ~((32'd1 << size_log2) - 32'd1);
    if (is_io) m = m & 32'h0000_FFFC;
    else       m = m & 32'hFFFF_FFF0;
    return m;
  endfunction

  typedef struct packed {
    logic          hit;
    logic [DW-1:0] old_base;
    logic [DW-1:0] new_base;
  } reloc_t;
endpackage

// File: rtl/bar_write_merge.sv
module bar_write_merge
  import bar_pkg::*;
#(
  parameter logic [DW-1:0] ADDR_MASK = 32'hFFFF_F000,
  parameter logic [DW-1:0] FLAG_VAL  = 32'h0
) (
  input  logic [DW-1:0]    cur_i,
  input  logic [LANES-1:0] be_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    next_o,
  output logic [DW-1:0]    cand_base_o
);
  logic [DW-1:0] merged;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[8*g +: 8] = be_i[g] ? wdata_i[8*g +: 8] : cur_i[8*g +: 8];
  end

  assign cand_base_o = merged & ADDR_MASK;
  assign next_o      = cand_base_o | FLAG_VAL;
endmodule

// File: rtl/bar_reloc_detect.sv
module bar_reloc_detect
  import bar_pkg::*;
#(
  parameter logic [DW-1:0] ADDR_MASK = 32'hFFFF_F000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] cand_base_i,
  output logic [DW-1:0] base_o,
  output reloc_t        evt_o
);
  logic   is_probe, is_same;
  reloc_t evt_d;

  assign is_probe       = (cand_base_i == ADDR_MASK);
  assign is_same        = (cand_base_i == base_o);
  assign evt_d.hit      = wr_en_i && !is_probe && !is_same;
  assign evt_d.old_base = base_o;
  assign evt_d.new_base = cand_base_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      evt_o  <= '0;
    end else begin
      evt_o.hit <= evt_d.hit;
      if (evt_d.hit) begin
        base_o         <= cand_base_i;
        evt_o.old_base <= evt_d.old_base;
        evt_o.new_base <= evt_d.new_base;
      end
    end
  end
endmodule

// File: rtl/bar_reg.sv
module bar_reg
  import bar_pkg::*;
#(
  parameter bit         IS_IO     = 1'b0,
  parameter int         SIZE_LOG2 = 12,
  parameter logic [3:0] MEM_FLAGS = 4'b1000,
  parameter logic [1:0] IO_FLAGS  = 2'b01
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic [31:0] base_o,
  output logic        win_en_o,
  output logic        reloc_o,
  output logic [31:0] old_base_o,
  output logic [31:0] new_base_o,
  output logic        release_o,
  output logic        claim_o
);
  localparam logic [DW-1:0] ADDR_MASK = addr_mask(IS_IO, SIZE_LOG2);
  localparam logic [DW-1:0] FLAG_VAL  = IS_IO ? {30'b0, IO_FLAGS} : {28'b0, MEM_FLAGS};

  logic [DW-1:0] bar_q, bar_d, cand_base;
  reloc_t        evt;

  bar_write_merge #(.ADDR_MASK(ADDR_MASK), .FLAG_VAL(FLAG_VAL)) u_merge (
    .cur_i       (bar_q),
    .be_i        (be_i),
    .wdata_i     (wdata_i),
    .next_o      (bar_d),
    .cand_base_o (cand_base)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bar_q <= FLAG_VAL;
    else if (wr_en_i) bar_q <= bar_d;
  end

  bar_reloc_detect #(.ADDR_MASK(ADDR_MASK)) u_detect (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .cand_base_i (cand_base),
    .base_o      (base_o),
    .evt_o       (evt)
  );

  assign rdata_o    = bar_q;
  assign win_en_o   = |base_o;
  assign reloc_o    = evt.hit;
  assign old_base_o = evt.old_base;
  assign new_base_o = evt.new_base;
  assign release_o  = evt.hit && |evt.old_base;
  assign claim_o    = evt.hit && |evt.new_base;
endmodule

// File: rtl/bar_reg_chk.sv
module bar_reg_chk #(
  parameter bit         IS_IO     = 1'b0,
  parameter int         SIZE_LOG2 = 12,
  parameter logic [3:0] MEM_FLAGS = 4'b1000,
  parameter logic [1:0] IO_FLAGS  = 2'b01
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] rdata_o,
  input logic [31:0] base_o,
  input logic        reloc_o,
  input logic [31:0] old_base_o,
  input logic [31:0] new_base_o,
  input logic        release_o,
  input logic        claim_o
);
  localparam logic [31:0] LOW_M  = (32'd1 << SIZE_LOG2) - 32'd1;
  localparam logic [31:0] FLAG_M = IS_IO ? 32'h3 : 32'hF;
  localparam logic [31:0] FLAG_V = IS_IO ? {30'b0, IO_FLAGS} : {28'b0, MEM_FLAGS};
  localparam logic [31:0] HI_M   = IS_IO ? 32'hFFFF_0000 : 32'h0;
  localparam logic [31:0] PROBE  = ~LOW_M & ~FLAG_M & ~HI_M;

  a_r3_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & LOW_M & ~FLAG_M) == 32'h0);
  a_r4_flags_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & FLAG_M) == FLAG_V);
  a_r5_io_high_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & HI_M) == 32'h0);
  a_r6_no_probe_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reloc_o |-> new_base_o != PROBE);
  a_r7_event_changes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reloc_o |-> new_base_o != old_base_o);
  a_r8_base_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reloc_o |-> base_o == new_base_o);
  a_r8_base_moves_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(base_o) |-> reloc_o);
  a_r9_release_in_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |-> (reloc_o && old_base_o != 32'h0));
  a_r9_claim_in_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |-> (reloc_o && new_base_o != 32'h0));
endmodule

bind bar_reg bar_reg_chk #(
  .IS_IO(IS_IO), .SIZE_LOG2(SIZE_LOG2), .MEM_FLAGS(MEM_FLAGS), .IO_FLAGS(IO_FLAGS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rdata_o(rdata_o), .base_o(base_o),
  .reloc_o(reloc_o), .old_base_o(old_base_o), .new_base_o(new_base_o),
  .release_o(release_o), .claim_o(claim_o)
);

// File: tb/tb_bar_reg.sv
`timescale 1ns/1ps
module tb_bar_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // memory window dut: 4 KiB, flags 4'b1000
  logic        m_we = 1'b0;
  logic [3:0]  m_be = '0;
  logic [31:0] m_wd = '0;
  logic [31:0] m_rd, m_base, m_old, m_new;
  logic        m_win, m_ev, m_rel, m_clm;

  bar_reg dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(m_we), .be_i(m_be), .wdata_i(m_wd),
    .rdata_o(m_rd), .base_o(m_base), .win_en_o(m_win), .reloc_o(m_ev),
    .old_base_o(m_old), .new_base_o(m_new), .release_o(m_rel), .claim_o(m_clm)
  );

  // I/O window dut: 16 bytes, flags 2'b01
  logic        i_we = 1'b0;
  logic [3:0]  i_be = '0;
  logic [31:0] i_wd = '0;
  logic [31:0] i_rd, i_base, i_old, i_new;
  logic        i_win, i_ev, i_rel, i_clm;

  bar_reg #(.IS_IO(1'b1), .SIZE_LOG2(4)) dut_io (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(i_we), .be_i(i_be), .wdata_i(i_wd),
    .rdata_o(i_rd), .base_o(i_base), .win_en_o(i_win), .reloc_o(i_ev),
    .old_base_o(i_old), .new_base_o(i_new), .release_o(i_rel), .claim_o(i_clm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Drive at negedge, check outputs at the following negedge (one cycle after the edge)
  task automatic mwr(input logic [31:0] d, input logic [3:0] be);
    @(negedge clk); m_we = 1'b1; m_wd = d; m_be = be;
    @(negedge clk); m_we = 1'b0;
  endtask

  task automatic iwr(input logic [31:0] d, input logic [3:0] be);
    @(negedge clk); i_we = 1'b1; i_wd = d; i_be = be;
    @(negedge clk); i_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 mem rdata", m_rd, 32'h0000_0008);
    chk("R1 mem base", m_base, 32'h0);
    chk("R1 mem win", {31'b0, m_win}, 32'h0);
    chk("R1 mem evt", {29'b0, m_ev, m_rel, m_clm}, 32'h0);
    chk("R1 io rdata", i_rd, 32'h0000_0001);
  endtask

  task automatic t_probe_from_zero;
    mwr(32'hFFFF_FFFF, 4'hF);
    chk("R6 probe readback", m_rd, 32'hFFFF_F008);
    chk("R6 probe no event", {31'b0, m_ev}, 32'h0);
    chk("R6 probe base kept", m_base, 32'h0);
  endtask

  task automatic t_first_reloc;
    mwr(32'hE000_1234, 4'hF);
    chk("R3 low bits cleared", m_rd, 32'hE000_1008);
    chk("R8 event", {31'b0, m_ev}, 32'h1);
    chk("R8 old base", m_old, 32'h0);
    chk("R8 new base", m_new, 32'hE000_1000);
    chk("R8 base follows", m_base, 32'hE000_1000);
    chk("R9 release/claim", {30'b0, m_rel, m_clm}, 32'h1);
    chk("R10 window on", {31'b0, m_win}, 32'h1);
    @(negedge clk);
    chk("R8 single pulse", {31'b0, m_ev}, 32'h0);
  endtask

  task automatic t_probe_restore;
    mwr(32'hFFFF_FFFF, 4'hF);
    chk("R6 probe no event", {31'b0, m_ev}, 32'h0);
    chk("R6 base kept", m_base, 32'hE000_1000);
    chk("R4 flags kept", m_rd, 32'hFFFF_F008);
    mwr(32'hE000_1000, 4'hF);
    chk("R7 restore no event", {31'b0, m_ev}, 32'h0);
    chk("R7 readback", m_rd, 32'hE000_1008);
  endtask

  task automatic t_byte_lane;
    mwr(32'hC5AA_AAA7, 4'b1000);
    chk("R2 top lane only", m_rd, 32'hC500_1008);
    chk("R8 lane event", {31'b0, m_ev}, 32'h1);
    chk("R8 lane old", m_old, 32'hE000_1000);
    chk("R8 lane new", m_new, 32'hC500_1000);
    chk("R9 both set", {30'b0, m_rel, m_clm}, 32'h3);
  endtask

  task automatic t_disable;
    mwr(32'h0000_0000, 4'hF);
    chk("R8 disable event", {31'b0, m_ev}, 32'h1);
    chk("R9 release only", {30'b0, m_rel, m_clm}, 32'h2);
    chk("R10 window off", {31'b0, m_win}, 32'h0);
    mwr(32'h0000_00FF, 4'b0001);
    chk("R3 in-window lane ignored", m_rd, 32'h0000_0008);
    chk("R7 zero again no event", {31'b0, m_ev}, 32'h0);
  endtask

  task automatic t_io;
    iwr(32'h1234_C0FF, 4'hF);
    chk("R5 io readback", i_rd, 32'h0000_C0F1);
    chk("R8 io event", {31'b0, i_ev}, 32'h1);
    chk("R8 io new", i_new, 32'h0000_C0F0);
    chk("R9 io claim", {30'b0, i_rel, i_clm}, 32'h1);
    iwr(32'hFFFF_FFFF, 4'hF);
    chk("R5 io probe readback", i_rd, 32'h0000_FFF1);
    chk("R6 io probe no event", {31'b0, i_ev}, 32'h0);
    chk("R6 io base kept", i_base, 32'h0000_C0F0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_probe_from_zero();
    t_first_reloc();
    t_probe_restore();
    t_byte_lane();
    t_disable();
    t_io();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule